// File: doc/BRIEF.md
# Clocked Synchronous Serial Byte Receiver

This block takes in a serial clock and a serial data line from an external master and builds 8-bit frames from them. Both lines are brought into the system clock domain through a two-flop synchronizer. On each detected rising edge of the synchronized serial clock, the block takes one data bit, starting with the least significant bit. Bits collect in an internal shift register. When the eighth bit lands, the frame is offered to a single holding register. The host sees that register as a valid/ready stream output.

Back-pressure works as follows. The holding register is one entry deep, and `rd_valid` stays high until the host accepts the byte by asserting `rd_ready` in a cycle where `rd_valid` is high. `rd_ready` has no effect while `rd_valid` is low. A frame that finishes while the byte is still unaccepted is not queued. It is discarded, the old byte is kept, and a sticky overrun flag is raised. While the overrun flag is set, every completed frame is discarded. The host clears the flag with a one-cycle clear strobe. If the clear and a new overrun fall in the same cycle, the flag is set.

Two level-sensitive interrupt outputs are gated by one interrupt enable. One requests service for a held byte and the other for an overrun. Dropping the receiver enable returns the bit counter and shift register to their start state, so reception always resumes on a frame boundary.

Top module: `sync_serial_rx`

## Requirements
- R1: A frame is 8 bits, one bit taken per rising edge of the serial clock. The first bit taken ends up in `rd_data[0]` and the eighth in `rd_data[7]`.
- R2: A frame that completes while `rd_valid` is 0 and the overrun flag is 0 is copied into `rd_data`, and `rd_valid` goes to 1.
- R3: A cycle with `rd_valid`=1 and `rd_ready`=1 clears `rd_valid` to 0. `rd_ready` while `rd_valid`=0 leaves `rd_valid` and `rd_data` unchanged.
- R4: A frame that completes while `rd_valid`=1 sets `ovr_flag` to 1, leaves `rd_data` holding the old byte, and keeps `rd_valid` at 1.
- R5: `ovr_flag` stays 1 until a cycle with `ovr_clr`=1. While it is 1, completed frames are discarded even when `rd_valid`=0.
- R6: `irq_rx` is 1 exactly when `rd_valid`=1 and `irq_en`=1.
- R7: `irq_err` is 1 exactly when `ovr_flag`=1 and `irq_en`=1.
- R8: While `rx_en`=0, serial clock edges shift nothing and the bit position returns to the start. A partial frame cut off by `rx_en`=0 is lost, and the next frame is received whole.
- R9: After reset, `rd_valid`, `ovr_flag`, `irq_rx` and `irq_err` are 0 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the bit counter at frame start |
| irq_en | input | 1 | Interrupt enable for both interrupt outputs |
| ser_clk | input | 1 | Serial clock from the master, asynchronous |
| ser_data | input | 1 | Serial data, LSB first, asynchronous |
| rd_data | output | 8 | Holding register contents |
| rd_valid | output | 1 | Holding register holds an unaccepted byte |
| rd_ready | input | 1 | Host accepts the byte when `rd_valid` is high |
| ovr_clr | input | 1 | One-cycle strobe that clears the overrun flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq_rx | output | 1 | Receive-data interrupt request (level) |
| irq_err | output | 1 | Receive-error interrupt request (level) |

## Verification
The bench drives single-bit bytes at both ends of the word (0x01 and 0x80) to catch a receiver that assembles MSB first or is off by one bit. It drives a second frame while the first byte is unaccepted; a design that overwrote the holding register or dropped `rd_valid` would show the new byte or an empty register. It sends a frame after the host has accepted the byte but before it has cleared the overrun flag; a design that resumed early would present that frame. It also cuts a frame off by dropping `rx_en` and then sends a whole byte; a design that kept the stale bit count would deliver a rotated value.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int unsigned FRAME_BITS   = 8;
  localparam int unsigned SYNC_DEPTH   = 2;

  // Outcome of offering a completed frame to the holding register.
  typedef enum logic [1:0] {
    OFFER_NONE   = 2'd0,
    OFFER_ACCEPT = 2'd1,
    OFFER_DROP   = 2'd2
  } offer_e;

  function automatic offer_e classify(input logic fv, input logic full, input logic ovr);
    if (!fv)              return OFFER_NONE;
    else if (full || ovr) return OFFER_DROP;
    else                  return OFFER_ACCEPT;
  endfunction
endpackage

// File: rtl/sr_sync_edge.sv
module sr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_async,
  input  logic sdat_async,
  output logic sclk_rise,
  output logic sdat_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sclk_q;
  logic [STAGES-1:0] sdat_q;
  logic              sclk_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sclk_q[0] <= 1'b0;
            sdat_q[0] <= 1'b0;
          end else begin
            sclk_q[0] <= sclk_async;
            sdat_q[0] <= sdat_async;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sclk_q[g] <= 1'b0;
            sdat_q[g] <= 1'b0;
          end else begin
            sclk_q[g] <= sclk_q[g-1];
            sdat_q[g] <= sdat_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_q[LAST];
  end

  assign sclk_rise = sclk_q[LAST] & ~sclk_prev;
  assign sdat_sync = sdat_q[LAST];

  // R1: one sample per serial clock edge, never two in a row
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/sr_shifter.sv
module sr_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bit_stb,
  input  logic             bit_val,
  output logic             frame_valid,
  output logic [WIDTH-1:0] frame_data
);
  localparam int unsigned CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(WIDTH - 1);

  logic [CW-1:0]    bit_cnt;
  logic [WIDTH-1:0] shreg;
  logic [WIDTH-1:0] shreg_nxt;

  assign shreg_nxt = {bit_val, shreg[WIDTH-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt     <= '0;
      shreg       <= '0;
      frame_valid <= 1'b0;
      frame_data  <= '0;
    end else if (!enable) begin
      bit_cnt     <= '0;
      shreg       <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (bit_stb) begin
        shreg <= shreg_nxt;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt     <= '0;
          frame_valid <= 1'b1;
          frame_data  <= shreg_nxt;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R8: disabled receiver returns to frame start
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (bit_cnt == '0) && !frame_valid);

  // R1: a frame completes only on a sampled bit
  frame_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(bit_stb && enable));
endmodule

// File: rtl/sr_holding.sv
module sr_holding
  import sync_rx_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic [WIDTH-1:0] frame_data,
  input  logic             rd_ready,
  input  logic             ovr_clr,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             ovr_flag
);
  offer_e offer;
  assign offer = classify(frame_valid, rd_valid, ovr_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (ovr_clr) ovr_flag <= 1'b0;
      case (offer)
        OFFER_ACCEPT: begin
          rd_data  <= frame_data;
          rd_valid <= 1'b1;
        end
        OFFER_DROP:   ovr_flag <= 1'b1;
        default:      ;
      endcase
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !rd_valid && !ovr_flag) |=> rd_valid && (rd_data == $past(frame_data)));

  // R4
  keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && rd_valid && !rd_ready) |=> rd_valid && ovr_flag && $stable(rd_data));

  // R3
  handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_valid);

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_flag) |-> $past(ovr_clr));

  // R5
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(frame_valid));
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import sync_rx_pkg::*;
#(
  parameter int unsigned DATA_W = FRAME_BITS,
  parameter int unsigned SYNC_N = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              irq_en,
  input  logic              ser_clk,
  input  logic              ser_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              ovr_clr,
  output logic              ovr_flag,
  output logic              irq_rx,
  output logic              irq_err
);
  logic              bit_stb;
  logic              bit_val;
  logic              fr_valid;
  logic [DATA_W-1:0] fr_data;

  sr_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_async(ser_clk),
    .sdat_async(ser_data),
    .sclk_rise (bit_stb),
    .sdat_sync (bit_val)
  );

  sr_shifter #(.WIDTH(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (rx_en),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .frame_valid(fr_valid),
    .frame_data (fr_data)
  );

  sr_holding #(.WIDTH(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_valid(fr_valid),
    .frame_data (fr_data),
    .rd_ready   (rd_ready),
    .ovr_clr    (ovr_clr),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .ovr_flag   (ovr_flag)
  );

  assign irq_rx  = rd_valid & irq_en;
  assign irq_err = ovr_flag & irq_en;

  // R7: an error request implies a dropped frame in the past
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_err) |-> ($past(fr_valid) || $past(!irq_en)));

  // R6: disabled interrupts stay quiet
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_rx && !irq_err);
endmodule

// File: tb/sync_serial_rx_tb.sv
module sync_serial_rx_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       irq_en = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       ovr_flag;
  logic       irq_rx;
  logic       irq_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .irq_en(irq_en),
    .ser_clk(ser_clk), .ser_data(ser_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .ovr_clr(ovr_clr), .ovr_flag(ovr_flag),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ser_data = b[i];
      idle(HALF);
      ser_clk = 1'b1;
      idle(HALF);
      ser_clk = 1'b0;
    end
    idle(8);
  endtask

  task automatic accept();
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_ovr();
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 rd_valid", {7'd0, rd_valid}, 8'd0);
    chk("R9 ovr_flag", {7'd0, ovr_flag}, 8'd0);
    chk("R9 irq_rx", {7'd0, irq_rx}, 8'd0);
    chk("R9 irq_err", {7'd0, irq_err}, 8'd0);
    chk("R9 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_byte(input logic [7:0] b);
    send_bits(b, 8);
    chk("R1 rd_data", rd_data, b);
    chk("R2 rd_valid", {7'd0, rd_valid}, 8'd1);
    chk("R6 irq_rx", {7'd0, irq_rx}, 8'd1);
    accept();
    chk("R3 rd_valid cleared", {7'd0, rd_valid}, 8'd0);
    chk("R6 irq_rx low", {7'd0, irq_rx}, 8'd0);
  endtask

  task automatic t_idle_ready();
    accept();
    chk("R3 idle ready valid", {7'd0, rd_valid}, 8'd0);
    chk("R3 idle ready data", rd_data, 8'h80);
  endtask

  task automatic t_overrun();
    send_bits(8'h11, 8);
    send_bits(8'h22, 8);
    chk("R4 data kept", rd_data, 8'h11);
    chk("R4 valid kept", {7'd0, rd_valid}, 8'd1);
    chk("R4 ovr set", {7'd0, ovr_flag}, 8'd1);
    chk("R7 irq_err", {7'd0, irq_err}, 8'd1);
    accept();
    chk("R3 valid after accept", {7'd0, rd_valid}, 8'd0);
    send_bits(8'h33, 8);
    chk("R5 discarded valid", {7'd0, rd_valid}, 8'd0);
    chk("R5 discarded data", rd_data, 8'h11);
    chk("R5 ovr sticky", {7'd0, ovr_flag}, 8'd1);
    clear_ovr();
    chk("R5 ovr cleared", {7'd0, ovr_flag}, 8'd0);
    chk("R7 irq_err low", {7'd0, irq_err}, 8'd0);
    send_bits(8'h44, 8);
    chk("R5 resume data", rd_data, 8'h44);
    chk("R5 resume valid", {7'd0, rd_valid}, 8'd1);
    accept();
  endtask

  task automatic t_irq_gate();
    irq_en = 1'b0;
    send_bits(8'h5A, 8);
    chk("R6 gated irq_rx", {7'd0, irq_rx}, 8'd0);
    send_bits(8'h6B, 8);
    chk("R7 gated irq_err", {7'd0, irq_err}, 8'd0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R7 enabled irq_err", {7'd0, irq_err}, 8'd1);
    chk("R6 enabled irq_rx", {7'd0, irq_rx}, 8'd1);
    accept();
    clear_ovr();
  endtask

  task automatic t_abort();
    send_bits(8'hFF, 3);
    rx_en = 1'b0;
    send_bits(8'hFF, 5);
    chk("R8 nothing while disabled", {7'd0, rd_valid}, 8'd0);
    rx_en = 1'b1;
    idle(2);
    send_bits(8'h96, 8);
    chk("R8 realigned data", rd_data, 8'h96);
    chk("R8 realigned valid", {7'd0, rd_valid}, 8'd1);
    accept();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(3);
    t_reset();
    rx_en  = 1'b1;
    irq_en = 1'b1;
    idle(2);
    t_byte(8'hA5);
    t_byte(8'h01);
    t_byte(8'h80);
    t_idle_ready();
    t_byte(8'h3C);
    t_overrun();
    t_irq_gate();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule